// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Port

This block is a serial master that sits on a 32-bit register bus. Software writes words into a 16-entry transmit queue. The port then sends each word as one frame, least significant frame bits only, most significant bit first. At the same time it collects the bits it receives into a 16-entry receive queue. One shifter produces three frame styles:

- A select-framed SPI style with programmable clock polarity and phase.
- A pulse-framed synchronous style in which a one-bit frame pulse precedes the data.
- A command/response style that sends a command of 8 or 16 bits, leaves one turnaround bit, and then captures the response.

Frame length is programmable from 4 to 16 bits. The bit rate is the bus clock divided by an even factor. The block also provides:

- an internal loopback path that feeds the transmit line back to the receiver;
- service requests, raised from programmable queue-level thresholds;
- a sticky overrun flag;
- a test register that forces the three interrupt conditions.

Register map (byte offsets):

| Offset | Register |
|---|---|
| 0x00 | control A |
| 0x04 | control B |
| 0x08 | status |
| 0x0C | test |
| 0x10 | data |

Top module: `syncser_port`

## Requirements
- R1: After reset, status reads 0x24, all other registers read 0, `ssp_sclk`=0, `ssp_frm`=1, `ssp_txd`=0 and `ssp_irq`=0.
- R2: Control A bits [3:0] hold the frame length minus one. Field values 0 to 2 are treated as 4 bits. The received word is the low frame-length bits of the sent word.
- R3: Control A bits [5:4] select the format: 0 is SPI style, 1 is pulse-framed, 2 is command/response. Code 3 behaves exactly as code 0.
- R4: Control B bit 2 loops the transmit line into the receiver. The received word then equals the sent word, masked to the frame length, MSB first.
- R5: One bit period is 2*(D+1) clocks, where D is control A bits [15:8]. Control A bit 7 enables the port. While the port is disabled, no frame starts and queued transmit words stay queued.
- R6: In SPI style, `ssp_frm` is low for the whole frame and one clock pulse is produced per bit. The idle clock level equals control B bit 3. Control B bit 4 = 0 delays the first rising clock edge by half a bit period after the frame starts; with bit 4 = 1 that edge coincides with the frame start (polarity 0).
- R7: In pulse-framed style, the clock idles low and `ssp_frm` idles low. `ssp_frm` is high for exactly one bit period before the data, and a frame of n bits has n+1 rising clock edges.
- R8: In command/response style, control B bit 5 selects a 16-bit command (1) or an 8-bit command (0), taken from the low bits of the transmit word. A frame has command+1+n rising clock edges, and the last n bits are captured from the receive line.
- R9: Status has these fields: bit 2 transmit not full, bit 3 receive not empty, bit 4 busy, bit 5 transmit request, bit 6 receive request, bit 7 overrun, [11:8] transmit level, [15:12] receive level. Levels are reported modulo 16.
- R10: The transmit request is active while the transmit level is below control B bits [9:6] plus 1. The receive request is active while the receive level is at least control B bits [13:10] plus 1.
- R11: Both queues hold 16 words in arrival order. A write to the data register while the transmit queue is full is dropped. Reading the data register while the receive queue is empty returns 0.
- R12: A frame that completes while the receive queue is full is discarded and sets the sticky overrun bit. Writing 1 to status bit 7 clears it. `ssp_irq` is the OR of overrun, receive request AND control B bit 0, and transmit request AND control B bit 1.
- R13: Test register bits 5, 6 and 7 force the transmit request, the receive request and the overrun flag respectively, for as long as they are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shifter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data-register read pops the receive queue |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| ssp_sclk | output | 1 | Serial clock |
| ssp_frm | output | 1 | Frame select or frame pulse |
| ssp_txd | output | 1 | Serial data out |
| ssp_rxd | input | 1 | Serial data in |
| ssp_irq | output | 1 | Combined interrupt |

## Verification
Register reads are combinational, and a write takes effect at the next clock edge. Status is therefore sampled at least one cycle after each write, always at the falling edge.

A frame begins one cycle after its word enters the queue. The received word is in the receive queue by the time busy falls. The bench waits three cycles after each write and then polls busy, and only then compares queue data or status.

Clock edges, frame-pulse width and the delay from select to first edge are counted in bus-clock cycles by monitors that are cleared before each frame. The counts are compared once the frame is over.

// File: rtl/syncser_port.sv
module syncser_port #(
  parameter int FIFO_D = 16,
  parameter int DW     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ssp_sclk,
  output logic        ssp_frm,
  output logic        ssp_txd,
  input  logic        ssp_rxd,
  output logic        ssp_irq
);
  localparam int PW = $clog2(FIFO_D);
  localparam int CW = PW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  logic [15:0] c0;
  logic [13:0] c1;
  logic [2:0]  tst;
  logic        ovr;
  st_t         st;
  logic [7:0]  dcnt;
  logic        half;
  logic [5:0]  slot;
  logic [DW-1:0] tx_word, rx_sh;

  logic [DW-1:0] txm [FIFO_D];
  logic [DW-1:0] rxm [FIFO_D];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire [2:0] sel  = bus_addr[4:2];
  wire [3:0] dss  = c0[3:0];
  wire [1:0] fmt  = c0[5:4];
  wire       en   = c0[7];
  wire [7:0] scr  = c0[15:8];
  wire lpbk = c1[2];
  wire spo  = c1[3];
  wire sph  = c1[4];
  wire mwds = c1[5];
  wire [3:0] tft = c1[9:6];
  wire [3:0] rft = c1[13:10];

  wire is_ti = (fmt == 2'd1);
  wire is_mw = (fmt == 2'd2);
  wire run   = (st == S_RUN);

  wire [5:0] nbits   = (dss < 4'd3) ? 6'd4 : {2'b0, dss} + 6'd1;
  wire [5:0] cmdlen  = mwds ? 6'd16 : 6'd8;
  wire [5:0] tx_len  = is_mw ? cmdlen : nbits;
  wire [5:0] tx_off  = is_ti ? 6'd1 : 6'd0;
  wire [5:0] rx_off  = is_ti ? 6'd1 : (is_mw ? cmdlen + 6'd1 : 6'd0);
  wire [5:0] last    = rx_off + nbits - 6'd1;
  wire [5:0] tidx    = slot - tx_off;
  wire [5:0] bidx    = tx_len - 6'd1 - tidx;
  wire in_tx = (slot >= tx_off) && (tidx < tx_len);
  wire in_rx = (slot >= rx_off);

  wire tick    = (dcnt == scr);
  wire tx_full = (tx_cnt == CW'(FIFO_D));
  wire rx_full = (rx_cnt == CW'(FIFO_D));
  wire start   = (st == S_IDLE) && en && (tx_cnt != '0);
  wire fend    = run && en && tick && half && (slot == last);
  wire tx_push = bus_wr && (sel == 3'd4) && !tx_full;
  wire rx_pop  = bus_rd && (sel == 3'd4) && (rx_cnt != '0);
  wire rx_push = fend && !rx_full;
  wire ovr_clr = bus_wr && (sel == 3'd2) && bus_wdata[7];
  wire rxbit   = lpbk ? ssp_txd : ssp_rxd;

  wire tfs  = (tx_cnt < CW'(tft) + CW'(1)) | tst[0];
  wire rfs  = (rx_cnt >= CW'(rft) + CW'(1)) | tst[1];
  wire ror  = ovr | tst[2];
  wire bsy  = (st != S_IDLE) || (en && tx_cnt != '0);
  wire [31:0] status = {16'b0, 4'(rx_cnt), 4'(tx_cnt), ror, rfs, tfs, bsy,
                        (rx_cnt != '0), !tx_full, 2'b0};

  always_comb begin
    if (run) begin
      if (is_ti)      ssp_sclk = ~half;
      else if (is_mw) ssp_sclk = half;
      else            ssp_sclk = spo ^ half ^ sph;
    end else begin
      ssp_sclk = (is_ti || is_mw) ? 1'b0 : spo;
    end
  end

  assign ssp_frm = is_ti ? (run && slot == 6'd0) : !run;
  assign ssp_txd = run && in_tx && tx_word[bidx[3:0]];
  assign ssp_irq = ror | (c1[0] & rfs) | (c1[1] & tfs);

  always_comb begin
    case (sel)
      3'd0: bus_rdata = {16'b0, c0};
      3'd1: bus_rdata = {18'b0, c1};
      3'd2: bus_rdata = status;
      3'd3: bus_rdata = {24'b0, tst, 5'b0};
      3'd4: bus_rdata = (rx_cnt != '0) ? {{(32-DW){1'b0}}, rxm[rx_rp]} : 32'b0;
      default: bus_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; tst <= '0; ovr <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (sel)
          3'd0: c0  <= bus_wdata[15:0];
          3'd1: c1  <= bus_wdata[13:0];
          3'd3: tst <= bus_wdata[7:5];
          default: ;
        endcase
      end
      if (fend && rx_full) ovr <= 1'b1;
      else if (ovr_clr)    ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push) rxm[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; half <= 1'b0; slot <= '0;
      tx_word <= '0; rx_sh <= '0;
    end else begin
      dcnt <= (st == S_IDLE || tick) ? 8'd0 : dcnt + 8'd1;
      case (st)
        S_IDLE: if (start) begin
          tx_word <= txm[tx_rp];
          rx_sh   <= '0;
          half    <= 1'b0;
          slot    <= '0;
          st      <= S_RUN;
        end
        S_RUN: begin
          if (!en) st <= S_IDLE;
          else if (tick) begin
            if (!half) begin
              half <= 1'b1;
              if (in_rx) rx_sh <= {rx_sh[DW-2:0], rxbit};
            end else begin
              half <= 1'b0;
              if (slot == last) st <= S_GAP;
              else slot <= slot + 6'd1;
            end
          end
        end
        default: if (tick || !en) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/syncser_port_chk.sv
module syncser_port_chk #(
  parameter int CW = 5,
  parameter int FD = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [4:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          run,
  input logic          idle,
  input logic          en,
  input logic [1:0]    fmt,
  input logic          sclk,
  input logic          frm,
  input logic          ovr,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  wire clr = bus_wr && (bus_addr[4:2] == 3'd2) && bus_wdata[7];

  a_r6_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fmt != 2'd1 && fmt != 2'd2) |-> !frm);

  a_r7_ti_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && fmt == 2'd1) |-> (!sclk && !frm));

  a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(FD)) && (rx_cnt <= CW'(FD)));

  a_r11_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == $past(rx_cnt)) || (rx_cnt == $past(rx_cnt) + CW'(1)) ||
    (rx_cnt == $past(rx_cnt) - CW'(1)));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && idle) |=> (tx_cnt >= $past(tx_cnt)));
endmodule

bind syncser_port syncser_port_chk #(.CW(CW), .FD(FIFO_D)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run(run), .idle(st == S_IDLE), .en(en), .fmt(fmt),
  .sclk(ssp_sclk), .frm(ssp_frm), .ovr(ovr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/syncser_port_tb.sv
module syncser_port_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, ssp_rxd = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ssp_sclk, ssp_frm, ssp_txd, ssp_irq;
  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_rise = 0, t_first = 0, t_second = 0, t_fall = 0, frm_cyc = 0;
  logic got_fall = 0;

  syncser_port u_dut (.*);

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ssp_frm) frm_cyc <= frm_cyc + 1;
  end
  always @(posedge ssp_sclk) begin
    if (n_rise == 0) t_first = cyc;
    if (n_rise == 1) t_second = cyc;
    n_rise = n_rise + 1;
  end
  always @(negedge ssp_frm) if (!got_fall) begin t_fall = cyc; got_fall = 1; end

  function automatic int eff_n(input int dss);
    return (dss < 3) ? 4 : dss + 1;
  endfunction
  function automatic logic [31:0] mask_w(input logic [31:0] w, input int dss);
    return w & ((32'd1 << eff_n(dss)) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      rd(5'h08, s);
      if (!s[4]) break;
    end
  endtask

  task automatic clr_meas();
    @(negedge clk); n_rise = 0; got_fall = 0; frm_cyc = 0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w [17];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h08, v); chk("R1 status", v, 32'h24);
    rd(5'h00, v); chk("R1 ctlA", v, 0);
    rd(5'h04, v); chk("R1 ctlB", v, 0);
    chk("R1 pins", {ssp_sclk, ssp_frm, ssp_txd, ssp_irq}, 4'b0100);

    // R4 R2 R3 random loopback frames, SPI and pulse-framed styles
    for (int i = 0; i < 14; i++) begin
      int dss = 3 + $urandom_range(0, 12);
      int f = $urandom_range(0, 1);
      logic [31:0] word = $urandom & 32'hFFFF;
      logic [31:0] cb = 32'h4 | ($urandom_range(0, 1) << 3) | ($urandom_range(0, 1) << 4);
      wr(5'h04, cb);
      wr(5'h00, dss | (f << 4) | 32'h80 | ($urandom_range(0, 3) << 8));
      wr(5'h10, word);
      wait_idle();
      rd(5'h10, v); chk("R4 loopback word", v, mask_w(word, dss));
    end

    // R2 small size field clamps to 4 bits
    wr(5'h04, 32'h4); wr(5'h00, 32'h81);
    wr(5'h10, 32'hFFFF); wait_idle();
    rd(5'h10, v); chk("R2 clamp to 4", v, 32'hF);

    // R6 R5 SPI timing, phase 0
    wr(5'h00, 32'h0387); clr_meas();
    wr(5'h10, 32'hA5); wait_idle();
    chk("R6 spi rises", n_rise, 8);
    chk("R5 bit period", t_second - t_first, 8);
    chk("R6 phase0 delay", t_first - t_fall, 4);
    rd(5'h10, v); chk("R4 spi data", v, 32'hA5);
    // phase 1
    wr(5'h04, 32'h14); clr_meas();
    wr(5'h10, 32'h5A); wait_idle();
    chk("R6 phase1 delay", t_first - t_fall, 0);
    rd(5'h10, v); chk("R4 spi ph1 data", v, 32'h5A);

    // R3 reserved code acts as SPI
    wr(5'h04, 32'h4); wr(5'h00, 32'hB7); clr_meas();
    wr(5'h10, 32'hC3); wait_idle();
    chk("R3 reserved rises", n_rise, 8);
    chk("R3 reserved select", got_fall, 1);
    rd(5'h10, v); chk("R3 reserved data", v, 32'hC3);

    // R6 R7 idle levels
    wr(5'h04, 32'h8); wr(5'h00, 32'h87); repeat (2) @(negedge clk);
    chk("R6 idle spo=1", {ssp_sclk, ssp_frm}, 2'b11);
    wr(5'h00, 32'h97); repeat (2) @(negedge clk);
    chk("R7 ti idle", {ssp_sclk, ssp_frm}, 2'b00);

    // R7 pulse-framed frame
    wr(5'h04, 32'h4); wr(5'h00, 32'h0297); clr_meas();
    wr(5'h10, 32'h3C); wait_idle();
    chk("R7 pulse width", frm_cyc, 6);
    chk("R7 ti rises", n_rise, 9);
    rd(5'h10, v); chk("R7 ti data", v, 32'h3C);

    // R8 command/response
    wr(5'h04, 32'h0); ssp_rxd = 1; wr(5'h00, 32'hA7); clr_meas();
    wr(5'h10, 32'h55); wait_idle();
    chk("R8 mw8 rises", n_rise, 17);
    rd(5'h10, v); chk("R8 mw8 data", v, 32'hFF);
    wr(5'h04, 32'h20); ssp_rxd = 0; wr(5'h00, 32'hA3); clr_meas();
    wr(5'h10, 32'h1234); wait_idle();
    chk("R8 mw16 rises", n_rise, 21);
    rd(5'h10, v); chk("R8 mw16 data", v, 0);

    // R13 test register forcing, R9 layout
    wr(5'h04, 32'h0); wr(5'h00, 32'h0F);
    wr(5'h10, 32'h77);
    rd(5'h08, v); chk("R9 one queued", v, 32'h104);
    wr(5'h0C, 32'h20); rd(5'h08, v); chk("R13 force tx req", v, 32'h124);
    wr(5'h0C, 32'h40); rd(5'h08, v); chk("R13 force rx req", v, 32'h144);
    wr(5'h0C, 32'h80); rd(5'h08, v); chk("R13 force overrun", v, 32'h184);
    chk("R12 irq from overrun", ssp_irq, 1);
    wr(5'h0C, 32'h0); rd(5'h08, v); chk("R13 release", v, 32'h104);
    wr(5'h04, 32'h4); wr(5'h00, 32'h8F); wait_idle();
    rd(5'h10, v); chk("R5 held word sent", v, 32'h77);

    // R5 R10 R11 queue and threshold behaviour while disabled
    wr(5'h00, 32'h0F); wr(5'h04, 32'h2 << 6);
    for (int i = 0; i < 17; i++) w[i] = $urandom & 32'hFFFF;
    for (int i = 0; i < 3; i++) wr(5'h10, w[i]);
    rd(5'h08, v); chk("R10 tx level 3 thr 3", v, 32'h304);
    wr(5'h04, 32'h3 << 6);
    rd(5'h08, v); chk("R10 tx level 3 thr 4", v, 32'h324);
    for (int i = 3; i < 17; i++) wr(5'h10, w[i]);
    wr(5'h04, 32'hF << 6);
    rd(5'h08, v); chk("R11 tx full", v, 32'h0);
    wr(5'h04, 32'h3C04); wr(5'h00, 32'h8F); wait_idle();
    rd(5'h08, v); chk("R10 rx full request", v, 32'h6C);
    // R12 overrun
    wr(5'h10, 32'hBEEF); wait_idle();
    rd(5'h08, v); chk("R12 overrun set", v, 32'hEC);
    chk("R12 irq", ssp_irq, 1);
    wr(5'h08, 32'h80);
    rd(5'h08, v); chk("R12 overrun clear", v, 32'h6C);
    for (int i = 0; i < 16; i++) begin
      rd(5'h10, v); chk("R11 fifo order", v, w[i]);
    end
    rd(5'h08, v); chk("R11 drained", v, 32'h24);
    rd(5'h10, v); chk("R11 empty read", v, 0);
    finish_up();
  end
endmodule